// File: doc/BRIEF.md
# Data-Space Address Decoder with Pointer Modes

This block turns a data-space access request into a decoded target. The request is either a direct 16-bit address or one of three 16-bit pointers. The block sorts the resulting effective address into one of three regions at the bottom of the space: general working registers, I/O registers, or internal SRAM. It reports the index within that region. An address above the last SRAM location raises an out-of-range flag.

For the pointer modes, the block builds the pointer from a pair of general-register bytes. It can add a 6-bit displacement, or apply a pre-decrement or a post-increment. For the two update modes it also returns the new pointer value, so the register pair can be written back.

One request may be accepted per cycle. The result appears on registered outputs one cycle after the request. The caller owns the register file and the SRAM; this block only steers the access.

Top module: `dspace_addr_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is zero.
- R2: `out_valid` equals `req_valid` of the previous cycle. After a cycle with `req_valid` low, every other output is zero.
- R3: An effective address from 0x0000 to 0x001F gives `target`=1 (general register) and `local_idx` equal to the address.
- R4: An effective address from 0x0020 to 0x005F gives `target`=2 (I/O) and `local_idx` equal to the address minus 0x20.
- R5: An effective address from 0x0060 to 0x045F gives `target`=3 (SRAM) and `local_idx` equal to the address minus 0x60.
- R6: An effective address above 0x045F gives `out_of_range`=1, `target`=0 and `local_idx`=0. Any pointer write-back for that request still takes place.
- R7: Mode 0 (direct) gives `eff_addr` equal to `direct_addr`, with no write-back. The pointer bytes, `ptr_sel` and `disp` have no effect in this mode.
- R8: Byte k of `ptr_bytes` (bits 8k+7:8k) is general register 26+k. `ptr_sel` 0, 1 and 2 pick X={byte1,byte0}, Y={byte3,byte2} and Z={byte5,byte4}. Mode 1 (indirect) gives `eff_addr` equal to the chosen pointer.
- R9: Mode 2 (displacement) with Y or Z gives `eff_addr` equal to the pointer plus the zero-extended `disp`, modulo 2^16.
- R10: Mode 3 (pre-decrement) gives `eff_addr` equal to the pointer minus 1, modulo 2^16. It sets `wb_en`=1 and `wb_sel`=`ptr_sel`, with `wb_value` equal to that same decremented value.
- R11: Mode 4 (post-increment) gives `eff_addr` equal to the unchanged pointer. It sets `wb_en`=1 and `wb_sel`=`ptr_sel`, with `wb_value` equal to the pointer plus 1, modulo 2^16.
- R12: Any of the following requests gives `bad_req`=1 with `target`, `local_idx`, `out_of_range`, `eff_addr`, `wb_en`, `wb_sel` and `wb_value` all zero:
  - mode 5, 6 or 7;
  - `ptr_sel`=3 in modes 1 to 4;
  - X in mode 2.
- R13: When `wb_en` is 0, both `wb_sel` and `wb_value` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code (0 to 4 legal) |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z |
| disp | input | 6 | Displacement for mode 2 |
| direct_addr | input | 16 | Address for mode 0 |
| ptr_bytes | input | 48 | General registers 26 to 31, byte k at bits 8k+7:8k |
| out_valid | output | 1 | Result valid |
| target | output | 2 | 0 none, 1 general register, 2 I/O, 3 SRAM |
| local_idx | output | 10 | Index within the selected region |
| out_of_range | output | 1 | Effective address above the SRAM top |
| bad_req | output | 1 | Illegal mode or pointer combination |
| eff_addr | output | 16 | Effective address |
| wb_en | output | 1 | Pointer write-back required |
| wb_sel | output | 2 | Pointer to write back |
| wb_value | output | 16 | New pointer value |

## Verification
The bench builds the block with its default sizes:
- 16-bit addresses;
- 32 general registers;
- 64 I/O registers;
- 1024 SRAM locations;
- a 6-bit displacement.

With these sizes, every region edge (0x1F/0x20, 0x5F/0x60, 0x45F/0x460) can be hit directly. The 16-bit wrap of pointer arithmetic, at 0x0000 and 0xFFFF, is also in reach. The random stimulus draws pointers near those edges and near the top of SRAM, so displacement and update modes cross region boundaries often.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_GPR  = 2'd1,
    TGT_IO   = 2'd2,
    TGT_SRAM = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_IND     = 3'd1,
    AM_DISP    = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_POSTINC = 3'd4
  } amode_e;
endpackage

// File: rtl/dsd_ptr_mux.sv
module dsd_ptr_mux #(
  parameter int ADDR_W = 16,
  parameter int NPTR   = 3,
  parameter int SEL_W  = 2
) (
  input  logic [NPTR*ADDR_W-1:0] ptr_bytes,
  input  logic [SEL_W-1:0]       sel,
  output logic [ADDR_W-1:0]      ptr,
  output logic                   ptr_ok
);
  localparam int HALF = ADDR_W / 2;

  logic [ADDR_W-1:0] words [NPTR];

  // Each pointer is a register pair: the even register is the low byte.
  for (genvar g = 0; g < NPTR; g++) begin : g_pair
    assign words[g] = {ptr_bytes[(2*g+1)*HALF +: HALF], ptr_bytes[2*g*HALF +: HALF]};
  end

  always_comb begin
    ptr    = '0;
    ptr_ok = 1'b0;
    for (int i = 0; i < NPTR; i++) begin
      if (sel == SEL_W'(i)) begin
        ptr    = words[i];
        ptr_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsd_ea_calc.sv
module dsd_ea_calc
  import dsd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DISP_W   = 6,
  parameter int SEL_W    = 2,
  parameter int NO_DISP_SEL = 0
) (
  input  logic [2:0]        mode,
  input  logic [SEL_W-1:0]  ptr_sel,
  input  logic              ptr_ok,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] direct_addr,
  output logic [ADDR_W-1:0] ea,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_val,
  output logic              bad
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    ea     = '0;
    wb_en  = 1'b0;
    wb_val = '0;
    bad    = 1'b0;
    case (amode_e'(mode))
      AM_DIRECT: ea = direct_addr;
      AM_IND: begin
        ea  = ptr;
        bad = !ptr_ok;
      end
      AM_DISP: begin
        ea  = ptr + ADDR_W'(disp);
        bad = !ptr_ok || (ptr_sel == SEL_W'(NO_DISP_SEL));
      end
      AM_PREDEC: begin
        ea     = ptr - ONE;
        wb_en  = ptr_ok;
        wb_val = ptr - ONE;
        bad    = !ptr_ok;
      end
      AM_POSTINC: begin
        ea     = ptr;
        wb_en  = ptr_ok;
        wb_val = ptr + ONE;
        bad    = !ptr_ok;
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/dsd_region.sv
module dsd_region
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GPR_N  = 32,
  parameter int IO_N   = 64,
  parameter int SRAM_N = 1024,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] ea,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx,
  output logic              oor
);
  localparam int IO_BASE   = GPR_N;
  localparam int SRAM_BASE = GPR_N + IO_N;
  localparam int LIMIT     = SRAM_BASE + SRAM_N;

  logic [ADDR_W-1:0] off;

  always_comb begin
    tgt = TGT_NONE;
    off = '0;
    oor = 1'b0;
    if (ea < ADDR_W'(IO_BASE)) begin
      tgt = TGT_GPR;
      off = ea;
    end else if (ea < ADDR_W'(SRAM_BASE)) begin
      tgt = TGT_IO;
      off = ea - ADDR_W'(IO_BASE);
    end else if (ea < ADDR_W'(LIMIT)) begin
      tgt = TGT_SRAM;
      off = ea - ADDR_W'(SRAM_BASE);
    end else begin
      oor = 1'b1;
    end
    idx = off[IDX_W-1:0];
  end
endmodule

// File: rtl/dspace_addr_decoder.sv
module dspace_addr_decoder
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int GPR_N  = 32,
  parameter int IO_N   = 64,
  parameter int SRAM_N = 1024,
  parameter int DISP_W = 6,
  parameter int NPTR   = 3,
  parameter int SEL_W  = 2,
  parameter int IDX_W  = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [2:0]             mode,
  input  logic [SEL_W-1:0]       ptr_sel,
  input  logic [DISP_W-1:0]      disp,
  input  logic [ADDR_W-1:0]      direct_addr,
  input  logic [NPTR*ADDR_W-1:0] ptr_bytes,
  output logic                   out_valid,
  output logic [1:0]             target,
  output logic [IDX_W-1:0]       local_idx,
  output logic                   out_of_range,
  output logic                   bad_req,
  output logic [ADDR_W-1:0]      eff_addr,
  output logic                   wb_en,
  output logic [SEL_W-1:0]       wb_sel,
  output logic [ADDR_W-1:0]      wb_value
);
  logic [ADDR_W-1:0] ptr, ea, wb_val_c;
  logic              ptr_ok, wb_c, bad_c, oor_c;
  tgt_e              tgt_c;
  logic [IDX_W-1:0]  idx_c;

  dsd_ptr_mux #(.ADDR_W(ADDR_W), .NPTR(NPTR), .SEL_W(SEL_W)) u_mux (
    .ptr_bytes(ptr_bytes), .sel(ptr_sel), .ptr(ptr), .ptr_ok(ptr_ok)
  );

  dsd_ea_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SEL_W(SEL_W), .NO_DISP_SEL(0)) u_ea (
    .mode(mode), .ptr_sel(ptr_sel), .ptr_ok(ptr_ok), .ptr(ptr), .disp(disp),
    .direct_addr(direct_addr), .ea(ea), .wb_en(wb_c), .wb_val(wb_val_c), .bad(bad_c)
  );

  dsd_region #(.ADDR_W(ADDR_W), .GPR_N(GPR_N), .IO_N(IO_N), .SRAM_N(SRAM_N), .IDX_W(IDX_W)) u_reg (
    .ea(ea), .tgt(tgt_c), .idx(idx_c), .oor(oor_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      target       <= TGT_NONE;
      local_idx    <= '0;
      out_of_range <= 1'b0;
      bad_req      <= 1'b0;
      eff_addr     <= '0;
      wb_en        <= 1'b0;
      wb_sel       <= '0;
      wb_value     <= '0;
    end else begin
      out_valid    <= req_valid;
      bad_req      <= req_valid && bad_c;
      target       <= (req_valid && !bad_c) ? tgt_c : TGT_NONE;
      local_idx    <= (req_valid && !bad_c) ? idx_c : '0;
      out_of_range <= req_valid && !bad_c && oor_c;
      eff_addr     <= (req_valid && !bad_c) ? ea : '0;
      wb_en        <= req_valid && !bad_c && wb_c;
      wb_sel       <= (req_valid && !bad_c && wb_c) ? ptr_sel : '0;
      wb_value     <= (req_valid && !bad_c && wb_c) ? wb_val_c : '0;
    end
  end
endmodule

// File: rtl/dspace_addr_decoder_chk.sv
module dspace_addr_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int GPR_N  = 32,
  parameter int IO_N   = 64,
  parameter int SRAM_N = 1024,
  parameter int SEL_W  = 2,
  parameter int IDX_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        mode,
  input logic              out_valid,
  input logic [1:0]        target,
  input logic [IDX_W-1:0]  local_idx,
  input logic              out_of_range,
  input logic              bad_req,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              wb_en,
  input logic [SEL_W-1:0]  wb_sel,
  input logic [ADDR_W-1:0] wb_value
);
  localparam int LIMIT = GPR_N + IO_N + SRAM_N;

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !wb_en && !bad_req && target == 2'd0));
  assert_gpr_index_R3: assert property (@(posedge clk) disable iff (rst)
    (target == 2'd1) |-> (32'(local_idx) < GPR_N && eff_addr == ADDR_W'(local_idx)));
  assert_oor_no_target_R6: assert property (@(posedge clk) disable iff (rst)
    out_of_range |-> (target == 2'd0 && out_valid && 32'(eff_addr) >= LIMIT));
  assert_predec_match_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 3'd3) |=> (!wb_en || wb_value == eff_addr));
  assert_postinc_step_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 3'd4) |=> (!wb_en || wb_value == eff_addr + ADDR_W'(1)));
  assert_bad_clean_R12: assert property (@(posedge clk) disable iff (rst)
    bad_req |-> (target == 2'd0 && !out_of_range && !wb_en && eff_addr == '0));
  assert_wb_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !wb_en |-> (wb_sel == '0 && wb_value == '0));
endmodule

bind dspace_addr_decoder dspace_addr_decoder_chk #(
  .ADDR_W(ADDR_W), .GPR_N(GPR_N), .IO_N(IO_N), .SRAM_N(SRAM_N), .SEL_W(SEL_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .out_valid(out_valid),
  .target(target), .local_idx(local_idx), .out_of_range(out_of_range), .bad_req(bad_req),
  .eff_addr(eff_addr), .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value)
);

// File: tb/tb_dspace_addr_decoder.sv
`timescale 1ns/1ps
module tb_dspace_addr_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  mode;
  logic [1:0]  ptr_sel;
  logic [5:0]  disp;
  logic [15:0] direct_addr;
  logic [47:0] ptr_bytes;
  logic        out_valid, out_of_range, bad_req, wb_en;
  logic [1:0]  target, wb_sel;
  logic [9:0]  local_idx;
  logic [15:0] eff_addr, wb_value;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dspace_addr_decoder dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .ptr_sel(ptr_sel),
    .disp(disp), .direct_addr(direct_addr), .ptr_bytes(ptr_bytes),
    .out_valid(out_valid), .target(target), .local_idx(local_idx),
    .out_of_range(out_of_range), .bad_req(bad_req), .eff_addr(eff_addr),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value)
  );

  // {valid, target, idx, oor, bad, ea, wb_en, wb_sel, wb_value} = 50 bits
  function automatic logic [49:0] pack_out();
    return {out_valid, target, local_idx, out_of_range, bad_req, eff_addr, wb_en, wb_sel, wb_value};
  endfunction

  function automatic logic [49:0] expect_out(logic v, logic [2:0] m, logic [1:0] s,
                                             logic [5:0] d, logic [15:0] da, logic [47:0] pb);
    logic [15:0] p, ea, wv;
    logic bad, we, oor;
    logic [1:0] t;
    logic [9:0] ix;
    if (!v) return '0;
    p = (s == 2'd0) ? pb[15:0] : (s == 2'd1) ? pb[31:16] : pb[47:32];
    bad = 1'b0; we = 1'b0; wv = 16'h0; ea = 16'h0;
    if (m > 3'd4) bad = 1'b1;
    else if (m != 3'd0 && s == 2'd3) bad = 1'b1;
    else if (m == 3'd2 && s == 2'd0) bad = 1'b1;
    if (bad) return {1'b1, 2'd0, 10'd0, 1'b0, 1'b1, 16'h0, 1'b0, 2'd0, 16'h0};
    case (m)
      3'd0: ea = da;
      3'd1: ea = p;
      3'd2: ea = p + {10'd0, d};
      3'd3: begin ea = p - 16'd1; we = 1'b1; wv = ea; end
      default: begin ea = p; we = 1'b1; wv = p + 16'd1; end
    endcase
    oor = 1'b0; ix = 10'd0; t = 2'd0;
    if (ea <= 16'h001F) begin t = 2'd1; ix = ea[9:0]; end
    else if (ea <= 16'h005F) begin t = 2'd2; ix = 10'(ea - 16'h20); end
    else if (ea <= 16'h045F) begin t = 2'd3; ix = 10'(ea - 16'h60); end
    else oor = 1'b1;
    return {1'b1, t, ix, oor, 1'b0, ea, we, we ? s : 2'd0, wv};
  endfunction

  function automatic string tag_of(logic [2:0] m, logic [1:0] s);
    if (m > 3'd4 || (m != 3'd0 && s == 2'd3) || (m == 3'd2 && s == 2'd0)) return "R12";
    case (m)
      3'd0: return "R7";
      3'd1: return "R8";
      3'd2: return "R9";
      3'd3: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [49:0] exp_v);
    logic [49:0] act;
    act = pack_out();
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic drive(logic v, logic [2:0] m, logic [1:0] s, logic [5:0] d,
                       logic [15:0] da, logic [47:0] pb, string tag);
    logic [49:0] e;
    @(negedge clk);
    req_valid = v; mode = m; ptr_sel = s; disp = d; direct_addr = da; ptr_bytes = pb;
    e = expect_out(v, m, s, d, da, pb);
    @(negedge clk);
    check(tag, e);
  endtask

  function automatic logic [15:0] edge_ptr();
    case ($urandom % 5)
      0: return 16'($urandom % 16'h0070);
      1: return 16'h0440 + 16'($urandom % 16'h0040);
      2: return 16'hFFF0 + 16'($urandom % 16);
      3: return 16'($urandom % 16'h0480);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] pb;
    int seed_sink;
    seed_sink = $urandom(32'd20240611);
    rst = 1'b1; req_valid = 1'b1; mode = 3'd4; ptr_sel = 2'd1; disp = 6'd5;
    direct_addr = 16'h0010; ptr_bytes = 48'h0123_4567_89AB;
    repeat (3) @(negedge clk);
    check("R1", '0);                     // during reset
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1", '0);                     // first cycle after reset, no request

    // R2: idle cycle after a request clears outputs
    drive(1'b1, 3'd0, 2'd0, 6'd0, 16'h0100, '0, "R2");
    drive(1'b0, 3'd4, 2'd1, 6'd3, 16'h0100, 48'hFFFF_FFFF_FFFF, "R2");

    // Region boundaries through direct mode
    drive(1'b1, 3'd0, 2'd0, 6'd0, 16'h0000, '0, "R3");
    drive(1'b1, 3'd0, 2'd0, 6'd0, 16'h001F, '0, "R3");
    drive(1'b1, 3'd0, 2'd0, 6'd0, 16'h0020, '0, "R4");
    drive(1'b1, 3'd0, 2'd0, 6'd0, 16'h005F, '0, "R4");
    drive(1'b1, 3'd0, 2'd0, 6'd0, 16'h0060, '0, "R5");
    drive(1'b1, 3'd0, 2'd0, 6'd0, 16'h045F, '0, "R5");
    drive(1'b1, 3'd0, 2'd0, 6'd0, 16'h0460, '0, "R6");
    drive(1'b1, 3'd0, 2'd0, 6'd0, 16'hFFFF, '0, "R6");

    // R7: direct ignores pointers, select and displacement
    drive(1'b1, 3'd0, 2'd3, 6'd63, 16'h0042, 48'hFFFF_0000_1234, "R7");
    drive(1'b1, 3'd0, 2'd2, 6'd17, 16'h0042, 48'h0000_FFFF_0001, "R7");

    // R8: each pointer pair, byte order
    pb = {8'h04, 8'h21, 8'h00, 8'h3A, 8'h01, 8'h02};   // Z=0x0421 Y=0x003A X=0x0102
    drive(1'b1, 3'd1, 2'd0, 6'd0, 16'h0, pb, "R8");
    drive(1'b1, 3'd1, 2'd1, 6'd0, 16'h0, pb, "R8");
    drive(1'b1, 3'd1, 2'd2, 6'd0, 16'h0, pb, "R8");

    // R9: displacement, region crossing and wrap
    drive(1'b1, 3'd2, 2'd1, 6'd63, 16'h0, {16'h0, 16'h0420, 16'h0}, "R9");
    drive(1'b1, 3'd2, 2'd2, 6'd63, 16'h0, {16'hFFF0, 32'h0}, "R9");

    // R10 / R11 wrap and R6 write-back on out-of-range
    drive(1'b1, 3'd3, 2'd0, 6'd0, 16'h0, '0, "R10");
    drive(1'b1, 3'd3, 2'd1, 6'd0, 16'h0, {16'h0, 16'h0060, 16'h0}, "R10");
    drive(1'b1, 3'd4, 2'd2, 6'd0, 16'h0, {16'hFFFF, 32'h0}, "R11");
    drive(1'b1, 3'd4, 2'd0, 6'd0, 16'h0, {32'h0, 16'h045F}, "R11");

    // R12: illegal combinations
    drive(1'b1, 3'd2, 2'd0, 6'd4, 16'h0, 48'h0010_0010_0010, "R12");
    drive(1'b1, 3'd7, 2'd1, 6'd4, 16'h0010, 48'h0010_0010_0010, "R12");
    drive(1'b1, 3'd3, 2'd3, 6'd4, 16'h0010, 48'h0010_0010_0010, "R12");
    // R13: no write-back fields in indirect mode
    drive(1'b1, 3'd1, 2'd1, 6'd4, 16'h0, 48'h0010_0010_0010, "R13");

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] m;
      logic [1:0] s;
      logic v;
      v  = ($urandom % 8) != 0;
      m  = ($urandom % 10 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
      s  = ($urandom % 12 == 0) ? 2'd3 : 2'($urandom % 3);
      pb = {edge_ptr(), edge_ptr(), edge_ptr()};
      drive(v, m, s, 6'($urandom), edge_ptr(), pb, v ? tag_of(m, s) : "R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule